// File: doc/BRIEF.md
# Colour Lookup Table Register Interface

This block keeps a colour lookup table for an indexed-colour display: 256 main entries and 4 overlay entries, each holding an 8-bit red, green and blue value. Software reaches the table through 32-bit word accesses in a 16-byte register window. It first writes an entry number to a pointer register. Each later data access then moves through the red, green and blue parts of that entry. After the blue part, the pointer moves to the next entry on its own. A second write offset steers the same sequence onto the four overlay entries, such as the colours of a hardware cursor.

A separate combinational lookup port gives a display pipeline the 24-bit colour of any of the 260 entries. This port does not disturb the access sequence. Converting the colour codes into analogue levels is left to later stages.

Top module: `clut_regif`

## Requirements
- R1: After reset every entry reads black (all components 0), except main entry 255 and overlay entries 256 and 258, which read white (all components 8'hFF). The pointer is 0 and the component phase is red.
- R2: A write to byte offset 0 loads the pointer from data bits 31:24 and returns the phase to red.
- R3: A write to byte offset 4 stores data bits 31:24 into the main entry at the pointer. The component written follows the phase order red, green, blue.
- R4: A data access in the blue phase advances the pointer by one, modulo 256, and returns the phase to red. Data accesses in the red and green phases advance the phase and leave the pointer unchanged.
- R5: A write to byte offset 12 stores data bits 31:24 into overlay entry 256 + (pointer & 3). It uses the same phase order and the same pointer advance as R3 and R4.
- R6: Any read returns the current phase's component of the main entry at the pointer in bits 31:24, with bits 23:0 zero, at every offset including 12. A read advances the sequence as in R4. When no read is in progress, the read data is zero.
- R7: Reads and data writes share one phase counter. A read between two data writes therefore uses up a phase.
- R8: A write to any offset other than 0, 4 and 12 changes no entry, no pointer and no phase. This includes offset 8 and offsets that are not word aligned.
- R9: The lookup port returns {red, green, blue} in bits 23:16, 15:8 and 7:0 for entry numbers 0 to 259, and zero for larger numbers. Using it changes neither the pointer nor the phase.
- R10: The lookup port shows an entry's old value during the cycle in which a bus write to that entry is presented. It shows the new value from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | An access is presented this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| lk_idx | input | 9 | Entry number for the display lookup |
| lk_rgb | output | 24 | Colour of the looked-up entry |

## Verification
The display lookup and a bus write can land on the same entry in the same cycle. The bench provokes this by holding the lookup on the entry the pointer names while it presents a red write. It then judges the lookup value twice: in the write cycle it must still show the old colour, and after the clock edge it must show the new one. A second overlap comes from reads and writes that share one phase counter. A read placed between two data writes must use up the green phase, so the second write lands in blue.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int CW = 8;

  typedef enum logic [1:0] {
    PH_R = 2'd0,
    PH_G = 2'd1,
    PH_B = 2'd2
  } phase_e;

  typedef struct packed {
    logic [CW-1:0] r;
    logic [CW-1:0] g;
    logic [CW-1:0] b;
  } rgb_t;
endpackage

// File: rtl/clut_dec.sv
module clut_dec #(
  parameter int ADDR_W   = 4,
  parameter int OFS_PTR  = 0,
  parameter int OFS_MAIN = 4,
  parameter int OFS_OVL  = 12
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              ld_en,
  output logic              wr_main,
  output logic              wr_ovl,
  output logic              rd_en,
  output logic              step_en
);
  always_comb begin
    ld_en   = sel && wr && (addr == ADDR_W'(OFS_PTR));
    wr_main = sel && wr && (addr == ADDR_W'(OFS_MAIN));
    wr_ovl  = sel && wr && (addr == ADDR_W'(OFS_OVL));
    rd_en   = sel && !wr;
    step_en = wr_main || wr_ovl || rd_en;
  end
endmodule

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_val,
  input  logic             step_en,
  output logic [IDX_W-1:0] idx,
  output phase_e           phase
);
  logic [IDX_W-1:0] idx_d;
  phase_e           phase_d;
  logic             en;

  always_comb begin
    idx_d   = idx;
    phase_d = phase;
    if (ld_en) begin
      idx_d   = ld_val;
      phase_d = PH_R;
    end else if (step_en) begin
      unique case (phase)
        PH_R: phase_d = PH_G;
        PH_G: phase_d = PH_B;
        default: begin
          phase_d = PH_R;
          idx_d   = idx + IDX_W'(1);
        end
      endcase
    end
    en = ld_en || step_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_R;
    end else if (en) begin
      idx   <= idx_d;
      phase <= phase_d;
    end
  end
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int MAIN_N = 256,
  parameter int OVL_N  = 4,
  localparam int NE    = MAIN_N + OVL_N,
  localparam int EW    = $clog2(NE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [EW-1:0] waddr,
  input  phase_e        wph,
  input  logic [CW-1:0] wval,
  input  logic [EW-1:0] raddr_a,
  output rgb_t          rdat_a,
  input  logic [EW-1:0] raddr_b,
  output rgb_t          rdat_b
);
  rgb_t ent_q [NE];

  for (genvar e = 0; e < NE; e++) begin : g_ent
    localparam bit WHITE = (e == MAIN_N - 1) || (e == MAIN_N) || (e == MAIN_N + 2);
    logic ent_we;
    rgb_t ent_d;

    always_comb begin
      ent_we = we && (waddr == EW'(e));
      ent_d  = ent_q[e];
      unique case (wph)
        PH_R:    ent_d.r = wval;
        PH_G:    ent_d.g = wval;
        default: ent_d.b = wval;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[e] <= WHITE ? '1 : '0;
      end else if (ent_we) begin
        ent_q[e] <= ent_d;
      end
    end
  end

  always_comb begin
    rdat_a = '0;
    rdat_b = '0;
    if (int'(raddr_a) < NE) rdat_a = ent_q[raddr_a];
    if (int'(raddr_b) < NE) rdat_b = ent_q[raddr_b];
  end
endmodule

// File: rtl/clut_regif.sv
module clut_regif
  import clut_pkg::*;
#(
  parameter int MAIN_N  = 256,
  parameter int OVL_N   = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  localparam int NE     = MAIN_N + OVL_N,
  localparam int EW     = $clog2(NE),
  localparam int IDX_W  = $clog2(MAIN_N),
  localparam int OVL_W  = $clog2(OVL_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [EW-1:0]     lk_idx,
  output logic [3*CW-1:0]   lk_rgb
);
  logic             ld_en, wr_main, wr_ovl, rd_en, step_en;
  logic [IDX_W-1:0] seq_idx;
  phase_e           seq_ph;
  logic [EW-1:0]    wr_ent;
  logic [EW-1:0]    rd_ent;
  rgb_t             rd_rgb, lk_val;
  logic [CW-1:0]    rd_comp;

  clut_dec #(.ADDR_W(ADDR_W)) dec_i (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .ld_en(ld_en), .wr_main(wr_main), .wr_ovl(wr_ovl),
    .rd_en(rd_en), .step_en(step_en)
  );

  clut_seq #(.IDX_W(IDX_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_val(bus_wdata[DATA_W-1 -: IDX_W]),
    .step_en(step_en), .idx(seq_idx), .phase(seq_ph)
  );

  always_comb begin
    rd_ent = EW'(seq_idx);
    if (wr_ovl) wr_ent = EW'(MAIN_N) + EW'(seq_idx[OVL_W-1:0]);
    else        wr_ent = EW'(seq_idx);
  end

  clut_store #(.MAIN_N(MAIN_N), .OVL_N(OVL_N)) store_i (
    .clk(clk), .rst_n(rst_n),
    .we(wr_main || wr_ovl), .waddr(wr_ent), .wph(seq_ph),
    .wval(bus_wdata[DATA_W-1 -: CW]),
    .raddr_a(rd_ent), .rdat_a(rd_rgb),
    .raddr_b(lk_idx), .rdat_b(lk_val)
  );

  always_comb begin
    unique case (seq_ph)
      PH_R:    rd_comp = rd_rgb.r;
      PH_G:    rd_comp = rd_rgb.g;
      default: rd_comp = rd_rgb.b;
    endcase
    bus_rdata = rd_en ? {rd_comp, {(DATA_W-CW){1'b0}}} : '0;
    lk_rgb    = lk_val;
  end
endmodule

// File: rtl/clut_regif_chk.sv
module clut_regif_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int EW     = 9,
  parameter int NE     = 260
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [EW-1:0]     lk_idx,
  input logic [23:0]       lk_rgb,
  input logic [IDX_W-1:0]  cur_idx,
  input logic [1:0]        cur_phase
);
  logic is_ld, is_data, is_other;
  always_comb begin
    is_ld    = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));
    is_data  = bus_sel && (!bus_wr || bus_addr == ADDR_W'(4) || bus_addr == ADDR_W'(12));
    is_other = bus_sel && bus_wr && !is_ld && !is_data;
  end

  p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_ld |=> (cur_idx == $past(bus_wdata[DATA_W-1 -: IDX_W])) && (cur_phase == 2'd0));

  p_phase_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_phase != 2'd3);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_data && cur_phase == 2'd2) |=>
      (cur_phase == 2'd0) && (cur_idx == IDX_W'($past(cur_idx) + 1'b1)));

  p_shared_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_data && cur_phase != 2'd2) |=>
      (cur_phase == 2'($past(cur_phase) + 1'b1)) && $stable(cur_idx));

  p_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_other |=> $stable(cur_idx) && $stable(cur_phase));

  p_lookup_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> $stable(cur_idx) && $stable(cur_phase));

  p_lookup_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lk_idx) >= NE) |-> (lk_rgb == 24'd0));

  p_rdata_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |-> (bus_rdata[DATA_W-9:0] == '0));

  p_rdata_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0));
endmodule

bind clut_regif clut_regif_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .EW(EW), .NE(NE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .lk_idx(lk_idx), .lk_rgb(lk_rgb), .cur_idx(seq_idx), .cur_phase(seq_ph)
);

// File: tb/clut_regif_tb_top.sv
`timescale 1ns/1ps
module clut_regif_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [8:0]  lk_idx;
  logic [23:0] lk_rgb;

  always #2.5 clk = ~clk;

  clut_regif dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_r [260];
  logic [7:0] m_g [260];
  logic [7:0] m_b [260];
  int m_idx;
  int m_ph;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_init();
    for (int e = 0; e < 260; e++) begin
      logic [7:0] v;
      v = (e == 255 || e == 256 || e == 258) ? 8'hFF : 8'h00;
      m_r[e] = v; m_g[e] = v; m_b[e] = v;
    end
    m_idx = 0; m_ph = 0;
  endtask

  function automatic logic [7:0] m_comp(input int e, input int ph);
    if (ph == 0) return m_r[e];
    if (ph == 1) return m_g[e];
    return m_b[e];
  endfunction

  task automatic model_step();
    if (m_ph == 2) begin m_ph = 0; m_idx = (m_idx + 1) % 256; end
    else m_ph++;
  endtask

  // Drives one access cycle from a falling edge; the caller stays in it until the next call.
  task automatic acc(input bit w, input logic [3:0] a, input logic [31:0] d, input string req);
    logic [31:0] exp;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    if (!w) begin
      exp = {m_comp(m_idx, m_ph), 24'h0};
      chk(bus_rdata == exp, req, bus_rdata, exp);
      model_step();
    end else if (a == 4'd0) begin
      m_idx = int'(d[31:24]); m_ph = 0;
    end else if (a == 4'd4 || a == 4'd12) begin
      int e;
      e = (a == 4'd12) ? 256 + (m_idx % 4) : m_idx;
      if (m_ph == 0) m_r[e] = d[31:24];
      else if (m_ph == 1) m_g[e] = d[31:24];
      else m_b[e] = d[31:24];
      model_step();
    end
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    #1;
  endtask

  task automatic look(input int e, input string req);
    logic [23:0] exp;
    lk_idx = 9'(e);
    #0.2;
    exp = (e < 260) ? {m_r[e], m_g[e], m_b[e]} : 24'h0;
    chk(lk_rgb == exp, req, {8'h0, lk_rgb}, {8'h0, exp});
  endtask

  task automatic look_all(input string req);
    for (int e = 0; e < 260; e++) look(e, req);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; lk_idx = '0;
    model_init();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;

    // R1: reset contents, R9: out-of-range lookup
    look_all("R1");
    look(260, "R9"); look(511, "R9");
    chk(bus_rdata == 32'h0, "R6", bus_rdata, 32'h0);
    acc(1'b0, 4'd4, 32'h0, "R1");
    acc(1'b0, 4'd4, 32'h0, "R1");
    acc(1'b0, 4'd4, 32'h0, "R1");
    idle();

    // R3/R4: fill every main entry through offset 4 with garbage in the low bits
    acc(1'b1, 4'd0, 32'h0000_0000, "R2");
    for (int i = 0; i < 256; i++) begin
      acc(1'b1, 4'd4, {8'(i ^ 8'h5A), 24'hA5C3F0}, "R3");
      acc(1'b1, 4'd4, {8'(i * 3),     24'h123456}, "R3");
      acc(1'b1, 4'd4, {8'(~i),        24'hFFFFFF}, "R3");
    end
    idle();
    look_all("R3");
    // R4: wrapped pointer now reads entry 0 red
    acc(1'b0, 4'd8, 32'h0, "R4");
    idle();

    // R6/R4: read sweep from 250 across the wrap to entry 3
    acc(1'b1, 4'd0, 32'hFA00_0000, "R2");
    for (int i = 0; i < 10 * 3; i++) acc(1'b0, 4'(4 * (i % 4)), 32'h0, "R6");
    idle();

    // R5: overlay writes starting at pointer 254 -> slots 2,3,0,1
    acc(1'b1, 4'd0, 32'hFE12_3456, "R2");
    for (int i = 0; i < 12; i++) acc(1'b1, 4'd12, {8'(8'h30 + 7 * i), 24'h0}, "R5");
    idle();
    for (int e = 256; e < 260; e++) look(e, "R5");
    acc(1'b0, 4'd12, 32'h0, "R6");
    acc(1'b0, 4'd12, 32'h0, "R6");
    idle();

    // R7: read in the middle of a write sequence
    acc(1'b1, 4'd0, 32'h0500_0000, "R2");
    acc(1'b1, 4'd4, 32'hC100_0000, "R7");
    acc(1'b0, 4'd4, 32'h0, "R7");
    acc(1'b1, 4'd4, 32'hC300_0000, "R7");
    acc(1'b0, 4'd4, 32'h0, "R7");
    idle();
    look(5, "R7");

    // R8: ignored offsets, then the sequence resumes untouched
    acc(1'b1, 4'd0, 32'h0900_0000, "R2");
    acc(1'b0, 4'd4, 32'h0, "R8");
    acc(1'b1, 4'd8,  32'hEE00_0000, "R8");
    acc(1'b1, 4'd1,  32'hEE00_0000, "R8");
    acc(1'b1, 4'd5,  32'hEE00_0000, "R8");
    acc(1'b1, 4'd14, 32'hEE00_0000, "R8");
    acc(1'b1, 4'd15, 32'hEE00_0000, "R8");
    acc(1'b0, 4'd4, 32'h0, "R8");
    acc(1'b0, 4'd4, 32'h0, "R8");
    acc(1'b0, 4'd4, 32'h0, "R8");
    idle();
    look_all("R8");

    // R10: lookup and write on the same entry in the same cycle
    acc(1'b1, 4'd0, 32'h1400_0000, "R2");
    idle();
    lk_idx = 9'd20;
    begin
      logic [23:0] old_v;
      old_v = {m_r[20], m_g[20], m_b[20]};
      acc(1'b1, 4'd4, 32'h7700_0000, "R10");
      chk(lk_rgb == old_v, "R10", {8'h0, lk_rgb}, {8'h0, old_v});
    end
    idle();
    look(20, "R10");

    // R9: lookup sweep during idle leaves the pointer alone
    look_all("R9");
    acc(1'b0, 4'd4, 32'h0, "R9");
    idle();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule